// File: doc/BRIEF.md
# Accumulator Processor with Register-Transfer Datapath

This block is a small stored-program processor with one accumulator. Program words and data share a single synchronous memory inside the block, and every access to it passes through an address register (MAR) and a data register (MDR). A control state machine walks each instruction through fetch, decode and execute, one register transfer per clock. The current state is brought out so the transfers can be followed from the ports.

While reset is held, the memory is filled through a load port. Once reset is released, execution starts at address 0 and continues until a halt instruction. The accumulator, program counter, an overflow flag, a halted flag and the state code are visible outputs. Instruction words are 16 bits: bits 15:12 hold the opcode and bits 11:0 hold an address or an immediate value. Only the low `MEM_AW` bits of an address select a memory word.

Reset is asynchronous and active-low. Its release passes through a two-stage synchronizer, so the core leaves reset two clock edges after `rst_n` rises.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is active, ACC, PC, the overflow flag and the halted flag read 0, and the state code reads 0 (fetch-address). Reset clears MAR, MDR and IR as well.
- R2: Every instruction is fetched in the order: state 0 (MAR gets PC), state 1 (memory read wait), state 2 (MDR gets the memory word and PC increments), state 3 (IR gets MDR), state 4 (decode). PC shows its old value in state 2 and the incremented value from state 3 on.
- R3: LOAD (opcode 0x1) passes through states 5, 6, 7 and 8 after decode. ACC ends up with memory[addr]. The instruction takes 9 cycles from one entry into state 1 to the next.
- R4: STORE (opcode 0x2) passes through states 9, 10 and 11 after decode. It writes ACC into memory[addr] and takes 8 cycles.
- R5: ADD (0x3) and SUB (0x4) use state 12. They set ACC to ACC plus or minus the 12-bit immediate, zero-extended. The result wraps modulo 2^16, and each takes 6 cycles.
- R6: Every ADD or SUB sets the overflow flag to 1 if, in two's complement, the result's sign disagrees with the operand signs (ADD: same-sign operands give an opposite-sign result). Otherwise the flag is set to 0. No other instruction changes the flag.
- R7: HALT (0xF) moves the machine to state 15. There the halted flag is 1, PC and ACC stay frozen, and no memory access is made until reset. Words after the HALT never execute.
- R8: Any other opcode is a no-op. It takes 5 cycles and leaves ACC and the flag unchanged.
- R9: The single memory port is used for at most one access per cycle. Reads are issued only in states 1 and 6, and a write only in state 11.
- R10: A write on the load port while reset is held stores load_data at load_addr. That word is the one later fetched or loaded from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Memory write strobe from the load port (use while in reset) |
| load_addr | input | MEM_AW | Load port word address |
| load_data | input | DATA_W | Load port write data |
| acc_o | output | DATA_W | Accumulator |
| pc_o | output | MEM_AW | Program counter |
| ovf_o | output | 1 | Signed overflow of the last ADD or SUB |
| halted_o | output | 1 | High while in the halted state |
| state_o | output | 4 | Control state code |

## Verification
The hardest behaviour to show from the ports is that STORE really writes memory, because memory has no read port to the outside. The bench writes a value with STORE, changes ACC, then reads the location back with LOAD. It also clears the target location beforehand, so a missing write shows up as zero. Cycle counts per opcode are measured as the spacing between entries into the read-wait state, using a program that mixes every instruction class. Signed-overflow boundaries are reached by loading 0x7FFF and 0x8000 from data words, since the immediate is only 12 bits wide.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    ST_FADDR  = 4'd0,
    ST_FWAIT  = 4'd1,
    ST_FCAP   = 4'd2,
    ST_FIR    = 4'd3,
    ST_DEC    = 4'd4,
    ST_LADDR  = 4'd5,
    ST_LWAIT  = 4'd6,
    ST_LCAP   = 4'd7,
    ST_LACC   = 4'd8,
    ST_SADDR  = 4'd9,
    ST_SDATA  = 4'd10,
    ST_SWRITE = 4'd11,
    ST_ALU    = 4'd12,
    ST_HALT   = 4'd15
  } cpu_state_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  // one port: a write wins; read data registered (one cycle latency)
  always_ff @(posedge clk) begin
    if (we)      store_q[addr] <= wdata;
    else if (re) rdata         <= store_q[addr];
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          ovf
);

  always_comb begin
    if (sub) begin
      res = a - b;
      ovf = (a[DW-1] != b[DW-1]) && (res[DW-1] != a[DW-1]);
    end else begin
      res = a + b;
      ovf = (a[DW-1] == b[DW-1]) && (res[DW-1] != a[DW-1]);
    end
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output cpu_state_e      state
);

  cpu_state_e state_d;

  always_comb begin
    state_d = ST_FADDR;
    case (state)
      ST_FADDR:  state_d = ST_FWAIT;
      ST_FWAIT:  state_d = ST_FCAP;
      ST_FCAP:   state_d = ST_FIR;
      ST_FIR:    state_d = ST_DEC;
      ST_DEC: begin
        case (opcode)
          OP_LOAD:        state_d = ST_LADDR;
          OP_STORE:       state_d = ST_SADDR;
          OP_ADD, OP_SUB: state_d = ST_ALU;
          OP_HALT:        state_d = ST_HALT;
          default:        state_d = ST_FADDR;
        endcase
      end
      ST_LADDR:  state_d = ST_LWAIT;
      ST_LWAIT:  state_d = ST_LCAP;
      ST_LCAP:   state_d = ST_LACC;
      ST_SADDR:  state_d = ST_SDATA;
      ST_SDATA:  state_d = ST_SWRITE;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= state_d;
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] acc_o,
  output logic [MEM_AW-1:0] pc_o,
  output logic              ovf_o,
  output logic              halted_o,
  output logic [3:0]        state_o
);

  localparam int FIELD_W = DATA_W - OP_W;

  logic              rst_sync_n;
  cpu_state_e        state_q;
  logic [MEM_AW-1:0] pc_q, pc_d;
  logic [FIELD_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d, ir_q, acc_q, acc_d;
  logic              ovf_q;
  logic              pc_en, mar_en, mdr_en, ir_en, acc_en, ovf_en;
  logic              core_re, core_we;
  logic [DATA_W-1:0] mem_rdata, alu_res;
  logic              alu_ovf;
  logic [DATA_W-1:0] imm_ext;

  acc_cpu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .opcode (ir_q[DATA_W-1 -: OP_W]),
    .state  (state_q)
  );

  acc_cpu_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .we    (load_en | core_we),
    .re    (core_re),
    .addr  (load_en ? load_addr : mar_q[MEM_AW-1:0]),
    .wdata (load_en ? load_data : mdr_q),
    .rdata (mem_rdata)
  );

  assign imm_ext = DATA_W'(ir_q[FIELD_W-1:0]);

  acc_cpu_alu #(.DW(DATA_W)) u_alu (
    .a   (acc_q),
    .b   (imm_ext),
    .sub (ir_q[DATA_W-1 -: OP_W] == OP_SUB),
    .res (alu_res),
    .ovf (alu_ovf)
  );

  // register-transfer decode: enables and next values per state
  always_comb begin
    pc_en  = 1'b0;  pc_d  = pc_q + 1'b1;
    mar_en = 1'b0;  mar_d = FIELD_W'(pc_q);
    mdr_en = 1'b0;  mdr_d = mem_rdata;
    ir_en  = 1'b0;
    acc_en = 1'b0;  acc_d = mdr_q;
    ovf_en = 1'b0;
    core_re = 1'b0;
    core_we = 1'b0;
    case (state_q)
      ST_FADDR:  mar_en = 1'b1;
      ST_FWAIT:  core_re = 1'b1;
      ST_FCAP: begin
        mdr_en = 1'b1;
        pc_en  = 1'b1;
      end
      ST_FIR:    ir_en = 1'b1;
      ST_LADDR, ST_SADDR: begin
        mar_en = 1'b1;
        mar_d  = ir_q[FIELD_W-1:0];
      end
      ST_LWAIT:  core_re = 1'b1;
      ST_LCAP:   mdr_en = 1'b1;
      ST_LACC:   acc_en = 1'b1;
      ST_SDATA: begin
        mdr_en = 1'b1;
        mdr_d  = acc_q;
      end
      ST_SWRITE: core_we = 1'b1;
      ST_ALU: begin
        acc_en = 1'b1;
        acc_d  = alu_res;
        ovf_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= mdr_q;
      if (acc_en) acc_q <= acc_d;
      if (ovf_en) ovf_q <= alu_ovf;
    end
  end

  assign acc_o    = acc_q;
  assign pc_o     = pc_q;
  assign ovf_o    = ovf_q;
  assign halted_o = (state_q == ST_HALT);
  assign state_o  = state_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        state,
  input logic [MEM_AW-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              halted,
  input logic              mem_re,
  input logic              mem_we
);

  // R2: fetch steps in fixed order
  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FADDR) |=> (state == ST_FWAIT));

  assert_fetch_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWAIT) |=> (state == ST_FCAP));

  // R2: PC moves by one in the capture step and nowhere else
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCAP) |=> (pc == MEM_AW'($past(pc) + 1'b1)));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_FCAP) |=> $stable(pc));

  // R3 / R5 / R8: ACC only changes at its two write states
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LACC && state != ST_ALU) |=> $stable(acc));

  // R7: halted stays put and stays off the memory port
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

  // R9: a data capture is always preceded by a read on the shared port
  assert_read_before_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LCAP || state == ST_FCAP) |-> $past(mem_re));

endmodule

bind acc_cpu_core acc_cpu_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .state  (state_q),
  .pc     (pc_q),
  .acc    (acc_q),
  .halted (halted_o),
  .mem_re (core_re),
  .mem_we (core_we)
);

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/1ps
module sim_acc_cpu_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [7:0]  load_addr;
  logic [15:0] load_data;
  logic [15:0] acc_o;
  logic [7:0]  pc_o;
  logic        ovf_o, halted_o;
  logic [3:0]  state_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  acc_cpu_core u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .acc_o(acc_o), .pc_o(pc_o), .ovf_o(ovf_o),
    .halted_o(halted_o), .state_o(state_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input string req);
    int cyc = 0;
    while (!halted_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(req, {31'd0, halted_o}, 32'd1);
  endtask

  task automatic t_reset();
    hold_reset();
    put(8'h00, 16'h3005);
    @(negedge clk);
    check("R1 acc", acc_o, 0); check("R1 pc", pc_o, 0);
    check("R1 state", state_o, 0); check("R1 halted", halted_o, 0);
    check("R1 ovf", ovf_o, 0);
    // mid-run reset
    put(8'h01, 16'h3005); put(8'h02, 16'h3005); put(8'h03, 16'hF000);
    release_reset();
    repeat (12) @(negedge clk);
    check("R1 running acc nonzero", {31'd0, acc_o != 0}, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async acc", acc_o, 0); check("R1 async pc", pc_o, 0);
    check("R1 async state", state_o, 0);
  endtask

  task automatic t_fetch_order();
    logic [3:0] exp [11] = '{4'd2, 4'd3, 4'd4, 4'd12, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd15, 4'd15};
    int cyc = 0;
    hold_reset();
    put(8'h00, 16'h3005); put(8'h01, 16'hF000);
    release_reset();
    while (state_o != 4'd1 && cyc < 20) begin @(negedge clk); cyc++; end
    check("R2 reached fetch wait", state_o, 1);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      check("R2 state sequence", state_o, exp[i]);
      if (i == 0) check("R2 pc old in capture", pc_o, 0);
      if (i == 1) check("R2 pc incremented before decode", pc_o, 1);
    end
    check("R5 add imm 5", acc_o, 16'h0005);
  endtask

  task automatic t_sub();
    hold_reset();
    put(8'h00, 16'h3014); put(8'h01, 16'h4005); put(8'h02, 16'h3FFF); put(8'h03, 16'hF000);
    release_reset();
    run_to_halt("R7 halt reached sub");
    check("R5 20-5+0xFFF", acc_o, 16'h100E);
    check("R6 no ovf", ovf_o, 0);
  endtask

  task automatic t_load_store();
    hold_reset();
    put(8'h80, 16'h1234); put(8'h81, 16'h0000);
    put(8'h00, 16'h1080); put(8'h01, 16'h2081); put(8'h02, 16'h3001);
    put(8'h03, 16'h1081); put(8'h04, 16'hF000);
    release_reset();
    run_to_halt("R7 halt reached ldst");
    check("R4 store then R3 load back", acc_o, 16'h1234);
    check("R7 pc after halt fetch", pc_o, 5);
  endtask

  task automatic t_cpi();
    int marks [5];
    int k = 0, cyc = 0;
    logic [3:0] prev = 4'd0;
    hold_reset();
    put(8'h80, 16'h1234);
    put(8'h00, 16'h0000); put(8'h01, 16'h3002); put(8'h02, 16'h1080);
    put(8'h03, 16'h2082); put(8'h04, 16'hF000);
    release_reset();
    while (k < 5 && cyc < 200) begin
      @(negedge clk); cyc++;
      if (state_o == 4'd1 && prev != 4'd1) begin marks[k] = cyc; k++; end
      prev = state_o;
    end
    check("R8 nop cycles", marks[1] - marks[0], 5);
    check("R5 add cycles", marks[2] - marks[1], 6);
    check("R3 load cycles", marks[3] - marks[2], 9);
    check("R4 store cycles", marks[4] - marks[3], 8);
    run_to_halt("R7 halt reached cpi");
    check("R3 load value", acc_o, 16'h1234);
  endtask

  task automatic t_nop();
    hold_reset();
    put(8'h00, 16'h3010); put(8'h01, 16'h5FFF); put(8'h02, 16'h9ABC);
    put(8'h03, 16'h0123); put(8'h04, 16'hF000);
    release_reset();
    run_to_halt("R7 halt reached nop");
    check("R8 acc untouched", acc_o, 16'h0010);
    check("R8 ovf untouched", ovf_o, 0);
    check("R8 pc", pc_o, 5);
  endtask

  task automatic t_ovf();
    hold_reset();
    put(8'h90, 16'h7FFF); put(8'h91, 16'h8000);
    put(8'h00, 16'h1090); put(8'h01, 16'h3001); put(8'h02, 16'hF000);
    release_reset();
    run_to_halt("R7 halt ovf a");
    check("R5 wrap to 0x8000", acc_o, 16'h8000); check("R6 add ovf", ovf_o, 1);

    hold_reset();
    put(8'h00, 16'h1091); put(8'h01, 16'h4001); put(8'h02, 16'hF000);
    release_reset();
    run_to_halt("R7 halt ovf b");
    check("R5 wrap to 0x7FFF", acc_o, 16'h7FFF); check("R6 sub ovf", ovf_o, 1);

    hold_reset();
    put(8'h02, 16'h4001); put(8'h03, 16'hF000);
    release_reset();
    run_to_halt("R7 halt ovf c");
    check("R5 0x7FFE", acc_o, 16'h7FFE); check("R6 ovf cleared by later sub", ovf_o, 0);

    hold_reset();
    put(8'h00, 16'h4001); put(8'h01, 16'hF000);
    release_reset();
    run_to_halt("R7 halt ovf d");
    check("R5 0-1 wraps", acc_o, 16'hFFFF); check("R6 no ovf through zero", ovf_o, 0);
  endtask

  task automatic t_halt();
    hold_reset();
    put(8'h00, 16'h3007); put(8'h01, 16'hF000); put(8'h02, 16'h3009);
    release_reset();
    run_to_halt("R7 halt reached");
    repeat (20) @(negedge clk);
    check("R7 still halted", halted_o, 1); check("R7 state", state_o, 15);
    check("R7 pc frozen", pc_o, 2); check("R7 acc frozen", acc_o, 16'h0007);
  endtask

  task automatic t_loadport();
    hold_reset();
    put(8'hA0, 16'hBEEF); put(8'hA0, 16'h0C0D);
    put(8'h00, 16'h10A0); put(8'h01, 16'hF000);
    release_reset();
    run_to_halt("R10 halt reached");
    check("R10 last load-port write kept", acc_o, 16'h0C0D);
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; load_addr = '0; load_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fetch_order();
    t_sub();
    t_load_store();
    t_cpi();
    t_nop();
    t_ovf();
    t_halt();
    t_loadport();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule